// File: doc/BRIEF.md
# Cascaded Delay-and-Invert Pulse Sequencer

This block builds a pulse train from a single trigger by chaining identical delay stages. Each stage waits a fixed number of clock cycles after it is started. It then inverts the level handed to it by the stage before, and passes a one-cycle start strobe to the stage after. Because each stage inverts the waveform it receives, the chain output changes level once per stage. A train of N pulses therefore needs 2N stages: one stage sets each rising edge and one sets each falling edge.

The trigger serves as the start of the first stage and as the shared enable of every stage. The first stage's level input is a fixed idle level set by a parameter. The sequence is given at compile time as a packed list of per-stage durations: an initial delay, then alternating active and idle lengths. Dropping the trigger clears every stage, and the output returns to the idle level. Raising the trigger again replays the whole sequence.

Top module: `pulse_chain`

## Requirements
- R1: While a stage has not finished its delay, its level output equals its level input. Once the delay has elapsed, the stage drives the inverted input level. The chain output therefore changes exactly once per stage.
- R2: Stage k makes its transition exactly D_k clock edges after its start becomes visible. Counting edges from the cycle in which the trigger is driven high, the k-th output transition appears after edge S_k = D_0 + ... + D_k.
- R3: The chain start output is high for exactly one cycle, after edge S_last, and low at all other times.
- R4: A duration of 1 is the minimum. With D_0 = 1, the first transition is visible after the first clock edge that samples the trigger high.
- R5: After the last transition the output holds its final level for as long as the trigger stays high.
- R6: At the first clock edge that samples the trigger low, every stage clears. The output then equals the idle level and the start output is low. This holds whether or not the sequence had finished.
- R7: A new rising trigger after any idle time, including a single low cycle, replays the sequence with the same timing as the first run.
- R8: The parameter INIT_LEVEL sets the idle output level. A value of 1 yields low-going pulses with the same timing.
- R9: The up-counting and down-counting timer variants, selected by the parameter CNT_STYLE, produce identical transition timing.
- R10: Under reset the output equals INIT_LEVEL and the start output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Trigger: starts the first stage and enables every stage |
| pulse_out | output | 1 | Level of the last stage, which is the generated pulse train |
| chain_start_out | output | 1 | One-cycle strobe from the last stage, usable to start a further chain |

## Verification
The hardest case to reach from the ports is a trigger that drops in the middle of a stage's count and rises again one cycle later. Every stage must then restart from zero, with no count left over from the aborted run. The stimulus sweeps the trigger hold time across every cycle of the sequence, for two configurations. After each hold it idles for one or several cycles and then re-arms. The output is compared each cycle against a level computed from the cumulative duration sums.

// File: rtl/pulse_chain_pkg.sv
package pulse_chain_pkg;

   typedef enum logic {
      CNT_UP   = 1'b0,
      CNT_DOWN = 1'b1
   } cnt_style_e;

   // Width of a counter that must hold the values 0 .. delay-1
   function automatic int cnt_width(input int delay);
      int w;
      w = 1;
      while ((1 << w) < delay) w++;
      return w;
   endfunction

endpackage

// File: rtl/pulse_step_timer.sv
module pulse_step_timer
   import pulse_chain_pkg::*;
#(
   parameter int         DELAY     = 1,
   parameter cnt_style_e CNT_STYLE = CNT_UP
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic expire
);

   localparam int          CNT_W = cnt_width(DELAY);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY - 1);

   generate
      if (DELAY < 1) begin : g_bad_delay
         $error("pulse_step_timer: DELAY must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   generate
      if (CNT_STYLE == CNT_UP) begin : g_up
         logic at_end;
         assign at_end = (cnt_q == LAST);
         assign expire = tick && at_end;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (clr) begin
               cnt_q <= '0;
            end else if (tick) begin
               if (at_end) cnt_q <= '0;
               else        cnt_q <= cnt_q + 1'b1;
            end
         end
      end else begin : g_down
         logic at_end;
         assign at_end = (cnt_q == '0);
         assign expire = tick && at_end;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= LAST;
            end else if (clr) begin
               cnt_q <= LAST;
            end else if (tick) begin
               if (at_end) cnt_q <= LAST;
               else        cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   endgenerate

   // R9: the counter never leaves the range 0 .. DELAY-1
   p_cnt_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

endmodule

// File: rtl/pulse_step.sv
module pulse_step
   import pulse_chain_pkg::*;
#(
   parameter int         DELAY     = 1,
   parameter cnt_style_e CNT_STYLE = CNT_UP
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic lvl_in,
   input  logic start_in,
   output logic lvl_out,
   output logic start_out
);

   logic running_q;
   logic done_q;
   logic strobe_q;
   logic active;
   logic expire;

   assign active = en && !done_q && (start_in || running_q);

   pulse_step_timer #(
      .DELAY     (DELAY),
      .CNT_STYLE (CNT_STYLE)
   ) timer_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (!en),
      .tick   (active),
      .expire (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         done_q    <= 1'b0;
         strobe_q  <= 1'b0;
      end else if (!en) begin
         running_q <= 1'b0;
         done_q    <= 1'b0;
         strobe_q  <= 1'b0;
      end else begin
         strobe_q <= 1'b0;
         if (expire) begin
            done_q    <= 1'b1;
            strobe_q  <= 1'b1;
            running_q <= 1'b0;
         end else if (active) begin
            running_q <= 1'b1;
         end
      end
   end

   assign lvl_out   = done_q ? ~lvl_in : lvl_in;
   assign start_out = strobe_q;

   // R3: the start strobe lasts exactly one cycle
   p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start_out |=> !start_out);

   // R3: a strobe only accompanies a finished stage
   p_strobe_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start_out |-> done_q);

   // R5: a finished stage stays finished while enabled
   p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && done_q) |=> done_q);

   // R6: a low enable clears the stage at the next edge
   p_idle_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!done_q && !start_out));

   // R2: no strobe without a start or an ongoing count
   p_no_unstarted_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_in && !running_q) |=> !start_out);

endmodule

// File: rtl/pulse_chain.sv
module pulse_chain
   import pulse_chain_pkg::*;
#(
   parameter int         NUM_STAGES  = 4,
   parameter int         DUR_W       = 8,
   parameter logic [NUM_STAGES*DUR_W-1:0] STEP_DELAYS =
      {8'd4, 8'd3, 8'd2, 8'd1},
   parameter logic       INIT_LEVEL  = 1'b0,
   parameter cnt_style_e CNT_STYLE   = CNT_UP
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic pulse_out,
   output logic chain_start_out
);

   generate
      if (NUM_STAGES < 1) begin : g_bad_stages
         $error("pulse_chain: NUM_STAGES must be at least 1");
      end
      if (DUR_W < 1 || DUR_W > 24) begin : g_bad_width
         $error("pulse_chain: DUR_W must lie in 1..24");
      end
   endgenerate

   logic [NUM_STAGES:0]   lvl_w;
   logic [NUM_STAGES-1:0] strobe_w;

   assign lvl_w[0] = INIT_LEVEL;

   generate
      for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
         localparam int D_I = int'(STEP_DELAYS[i*DUR_W +: DUR_W]);
         logic start_w;

         if (D_I < 1) begin : g_zero
            $error("pulse_chain: every stage duration must be at least 1");
         end

         if (i == 0) begin : g_head
            assign start_w = trig;
         end else begin : g_link
            assign start_w = strobe_w[i-1];
         end

         pulse_step #(
            .DELAY     (D_I),
            .CNT_STYLE (CNT_STYLE)
         ) step_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (trig),
            .lvl_in    (lvl_w[i]),
            .start_in  (start_w),
            .lvl_out   (lvl_w[i+1]),
            .start_out (strobe_w[i])
         );
      end
   endgenerate

   assign pulse_out       = lvl_w[NUM_STAGES];
   assign chain_start_out = strobe_w[NUM_STAGES-1];

   // R1: with the trigger steady high, output moves only with a stage strobe
   p_edge_needs_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && $past(trig) && (pulse_out != $past(pulse_out))) |-> (|strobe_w));

   // R6: a sampled-low trigger returns the output to idle
   p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !trig |=> ((pulse_out == INIT_LEVEL) && !chain_start_out));

   // R3: at most one stage strobes in any cycle
   p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(strobe_w));

   // R10: idle level while reset is applied
   p_reset_level_r10: assert property (@(posedge clk)
      !rst_n |-> ((pulse_out == INIT_LEVEL) && !chain_start_out));

endmodule

// File: tb/pulse_chain_tb_top.sv
module pulse_chain_tb_top;
   import pulse_chain_pkg::*;

   localparam int NS = 4;
   localparam int A_D[NS] = '{1, 2, 3, 4};
   localparam int B_D[NS] = '{1, 10, 25, 15};
   localparam logic A_INIT = 1'b0;
   localparam logic B_INIT = 1'b1;
   localparam int WATCHDOG = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trig_a = 1'b0;
   logic trig_b = 1'b0;
   logic out_a, out_b, stb_a, stb_b;

   int n_checks = 0;
   int n_fails  = 0;

   always #4 clk = ~clk;

   pulse_chain #(
      .NUM_STAGES  (NS),
      .DUR_W       (8),
      .STEP_DELAYS ({8'd4, 8'd3, 8'd2, 8'd1}),
      .INIT_LEVEL  (A_INIT),
      .CNT_STYLE   (CNT_UP)
   ) dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .trig            (trig_a),
      .pulse_out       (out_a),
      .chain_start_out (stb_a)
   );

   pulse_chain #(
      .NUM_STAGES  (NS),
      .DUR_W       (8),
      .STEP_DELAYS ({8'd15, 8'd25, 8'd10, 8'd1}),
      .INIT_LEVEL  (B_INIT),
      .CNT_STYLE   (CNT_DOWN)
   ) dut_b_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .trig            (trig_b),
      .pulse_out       (out_b),
      .chain_start_out (stb_b)
   );

   function automatic int dur(input int sel, input int k);
      return (sel == 0) ? A_D[k] : B_D[k];
   endfunction

   function automatic logic init_of(input int sel);
      return (sel == 0) ? A_INIT : B_INIT;
   endfunction

   function automatic int total(input int sel);
      int acc = 0;
      for (int k = 0; k < NS; k++) acc += dur(sel, k);
      return acc;
   endfunction

   // expected level after c edges with the trigger held high
   function automatic logic exp_level(input int sel, input int c);
      int   acc = 0;
      logic l   = init_of(sel);
      for (int k = 0; k < NS; k++) begin
         acc += dur(sel, k);
         if (c >= acc) l = ~l;
      end
      return l;
   endfunction

   function automatic bit is_edge(input int sel, input int c);
      int acc = 0;
      for (int k = 0; k < NS; k++) begin
         acc += dur(sel, k);
         if (c == acc) return 1'b1;
      end
      return 1'b0;
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
      end
   endtask

   task automatic set_trig(input int sel, input logic v);
      if (sel == 0) trig_a = v;
      else          trig_b = v;
   endtask

   function automatic logic get_out(input int sel);
      return (sel == 0) ? out_a : out_b;
   endfunction

   function automatic logic get_stb(input int sel);
      return (sel == 0) ? stb_a : stb_b;
   endfunction

   // hold trigger for 'hold' edges, then drop it for 'gap' edges
   task automatic run_seq(input int sel, input int hold, input int gap, input bit rearm);
      string tag;
      set_trig(sel, 1'b1);
      for (int c = 1; c <= hold; c++) begin
         @(posedge clk);
         @(negedge clk);
         if (c == 1)                   tag = "R4";
         else if (c > total(sel))      tag = "R5";
         else if (is_edge(sel, c))     tag = "R1";
         else                          tag = "R2";
         if (rearm) tag = {tag, "/R7"};
         if (sel == 1) tag = {tag, "/R9"};
         check(tag, get_out(sel), exp_level(sel, c));
         check("R3", get_stb(sel), (c == total(sel)) ? 1'b1 : 1'b0);
      end
      set_trig(sel, 1'b0);
      for (int g = 1; g <= gap; g++) begin
         @(posedge clk);
         @(negedge clk);
         check((sel == 1) ? "R6/R8" : "R6", get_out(sel), init_of(sel));
         check("R6", get_stb(sel), 1'b0);
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      // R10: reset state
      repeat (3) @(negedge clk);
      check("R10", out_a, A_INIT);
      check("R10", stb_a, 1'b0);
      check("R10/R8", out_b, B_INIT);
      check("R10", stb_b, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) begin
         @(negedge clk);
         check("R8", out_a, A_INIT);
         check("R8", out_b, B_INIT);
      end

      for (int sel = 0; sel < 2; sel++) begin
         // full run, then immediate replay after a single low cycle
         run_seq(sel, total(sel) + 3, 1, 1'b0);
         run_seq(sel, total(sel) + 3, 4, 1'b1);
         // abort at every cycle of the sequence, re-arm after one low cycle
         for (int h = 1; h <= total(sel) + 1; h++) begin
            run_seq(sel, h, 1, 1'b0);
            run_seq(sel, total(sel) + 1, 2, 1'b1);
         end
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule